// File: doc/BRIEF.md
# FIFO Replay Read Controller

This block is the read half of a single-clock FIFO that can replay its stored words from the start of its memory. Each enabled read moves one word from an external memory into a registered output and advances a read pointer. A full-width write pointer, already in the read clock domain, comes from the write side. The block compares it with the read pointer to produce the empty status.

An active-low replay request, sampled on a rising read-clock edge, returns the read pointer to memory location 0. A latency choice is captured while master reset is held. In zero-latency mode, the word at location 0 is loaded into the output register on the same edge that samples the request. In normal mode the output register holds its value, and word 0 arrives on the next enabled read.

Replay gives defined data only if the write side has written no more words than the memory depth since the last master reset.

Top module: `rtx_read_ctrl`

## Requirements
- R1: While master reset is held and after its release, `dout_o` is 0, `mem_addr_o` is 0 and the read pointer (including its wrap bit) is 0.
- R2: On an edge with `rd_en_i`=1, `rtx_n_i`=1 and `empty_o`=0, `dout_o` takes the word at `mem_addr_o`, and the address then advances by one, modulo DEPTH.
- R3: A read requested while `empty_o`=1 (and `rtx_n_i`=1) leaves `dout_o` and `mem_addr_o` unchanged.
- R4: `empty_o` is 1 exactly when the read pointer (DEPTH-modulo address plus one wrap bit) equals `wr_ptr_i`. After DEPTH reads from a full memory, the wrap bit makes the block empty again.
- R5: `rtx_n_i`=0 at a rising edge returns the read pointer to location 0.
- R6: The latency mode is taken from `lat_sel_i` while reset is in effect (0 = zero latency, 1 = normal latency). Changing `lat_sel_i` afterwards has no effect.
- R7: In zero-latency mode with `wr_ptr_i`≠0, `mem_addr_o` is 0 while `rtx_n_i`=0. On the edge that samples the request, `dout_o` loads word 0 and the read pointer becomes 1.
- R8: In normal mode, `dout_o` holds on the replay edge, and the next enabled read returns word 0.
- R9: When `rd_en_i`=1 and `rtx_n_i`=0 at the same edge, only the replay takes effect.
- R10: In zero-latency mode with `wr_ptr_i`=0, a replay leaves `dout_o` unchanged and the pointer at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Master reset, active low, asynchronous assert |
| lat_sel_i | input | 1 | Latency choice captured during reset: 0 zero latency, 1 normal |
| rd_en_i | input | 1 | Read enable, active high |
| rtx_n_i | input | 1 | Replay request, active low |
| wr_ptr_i | input | AW+1 | Write pointer with wrap bit, in read clock domain |
| mem_addr_o | output | AW | Read address to the storage array |
| mem_data_i | input | DW | Word read from the storage array at `mem_addr_o` |
| dout_o | output | DW | Registered output word |
| empty_o | output | 1 | No unread words |

## Verification
The bench goes after a replay that arrives together with a read enable. A design that let the read win would skip word 0 or load the wrong word. It replays in each latency mode: a mix-up shows either as an output that changes one edge too early or late, or as a pointer left at 0 instead of 1. It also replays into an empty memory in zero-latency mode, where a careless design would load stale data and then report that it is not empty. Finally it drains a memory holding exactly DEPTH words. An empty compare without the wrap bit would then flag the block empty while it is full, or keep reading past the last word.

// File: rtl/rtx_pkg.sv
package rtx_pkg;
  typedef enum logic {
    LAT_ZERO = 1'b0,
    LAT_NORM = 1'b1
  } lat_mode_e;
endpackage

// File: rtl/rtx_rst_sync.sv
module rtx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/rtx_ptr_ctl.sv
module rtx_ptr_ctl #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          zero_mode,
  input  logic          rd_en,
  input  logic          rtx_n,
  input  logic [AW:0]   wr_ptr,
  output logic [AW-1:0] mem_addr,
  output logic          load_en,
  output logic          empty
);
  localparam logic [AW:0] PTR_ZERO = '0;
  localparam logic [AW:0] PTR_ONE  = {{AW{1'b0}}, 1'b1};

  logic [AW:0] rd_ptr_q;
  logic [AW:0] rd_ptr_d;
  logic        rtx_req;
  logic        has_data;

  assign rtx_req  = ~rtx_n;
  assign empty    = (rd_ptr_q == wr_ptr);
  assign has_data = (wr_ptr != PTR_ZERO);

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    load_en  = 1'b0;
    mem_addr = rd_ptr_q[AW-1:0];
    if (rtx_req) begin
      rd_ptr_d = PTR_ZERO;
      if (zero_mode) begin
        mem_addr = '0;
        if (has_data) begin
          load_en  = 1'b1;
          rd_ptr_d = PTR_ONE;
        end
      end
    end else if (rd_en && !empty) begin
      load_en  = 1'b1;
      rd_ptr_d = rd_ptr_q + PTR_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) rd_ptr_q <= '0;
    else         rd_ptr_q <= rd_ptr_d;
  end
endmodule

// File: rtl/rtx_out_stage.sv
module rtx_out_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          load_en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] dout_q;
  logic [DW-1:0] dout_d;

  always_comb begin
    dout_d = dout_q;
    if (load_en) dout_d = din;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) dout_q <= '0;
    else         dout_q <= dout_d;
  end

  assign dout = dout_q;
endmodule

// File: rtl/rtx_read_ctrl.sv
module rtx_read_ctrl
  import rtx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lat_sel_i,
  input  logic          rd_en_i,
  input  logic          rtx_n_i,
  input  logic [AW:0]   wr_ptr_i,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_data_i,
  output logic [DW-1:0] dout_o,
  output logic          empty_o
);
  logic      rst_sn;
  lat_mode_e mode_q;
  lat_mode_e mode_d;
  logic      zero_mode;
  logic      load_en;

  rtx_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  always_comb begin
    mode_d = mode_q;
    if (!rst_sn) mode_d = lat_mode_e'(lat_sel_i);
  end

  always_ff @(posedge clk) begin
    mode_q <= mode_d;
  end

  assign zero_mode = (mode_q == LAT_ZERO);

  rtx_ptr_ctl #(.AW(AW)) u_ptr (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .zero_mode (zero_mode),
    .rd_en     (rd_en_i),
    .rtx_n     (rtx_n_i),
    .wr_ptr    (wr_ptr_i),
    .mem_addr  (mem_addr_o),
    .load_en   (load_en),
    .empty     (empty_o)
  );

  rtx_out_stage #(.DW(DW)) u_out (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .load_en (load_en),
    .din     (mem_data_i),
    .dout    (dout_o)
  );
endmodule

// File: rtl/rtx_read_ctrl_chk.sv
module rtx_read_ctrl_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_sn,
  input logic          zero_mode,
  input logic          rd_en_i,
  input logic          rtx_n_i,
  input logic [AW:0]   wr_ptr_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_data_i,
  input logic [DW-1:0] dout_o,
  input logic          empty_o
);
  p_read_load_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_en_i && rtx_n_i && !empty_o) |=> (dout_o == $past(mem_data_i)));

  p_empty_hold_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (empty_o && rtx_n_i) |=> $stable(dout_o));

  p_norm_addr_zero_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (!rtx_n_i && !zero_mode) |=> (mem_addr_o == '0));

  p_mode_kept_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(rst_sn) |-> $stable(zero_mode));

  p_zero_load_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (!rtx_n_i && zero_mode && (wr_ptr_i != '0)) |=> (dout_o == $past(mem_data_i)));

  p_norm_hold_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (!rtx_n_i && !zero_mode) |=> $stable(dout_o));

  p_zero_empty_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (!rtx_n_i && zero_mode && (wr_ptr_i == '0)) |=> $stable(dout_o));
endmodule

bind rtx_read_ctrl rtx_read_ctrl_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_sn     (rst_sn),
  .zero_mode  (zero_mode),
  .rd_en_i    (rd_en_i),
  .rtx_n_i    (rtx_n_i),
  .wr_ptr_i   (wr_ptr_i),
  .mem_addr_o (mem_addr_o),
  .mem_data_i (mem_data_i),
  .dout_o     (dout_o),
  .empty_o    (empty_o)
);

// File: tb/rtx_read_ctrl_bench.sv
module rtx_read_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 8;
  localparam int DEPTH = 16;
  localparam int AW    = 4;

  logic          clk;
  logic          rst_n;
  logic          lat_sel;
  logic          rd_en;
  logic          rtx_n;
  logic [AW:0]   wr_ptr;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic [DW-1:0] dout;
  logic          empty;
  logic [DW-1:0] bmem [DEPTH];

  int    n_checks;
  int    n_errors;
  int    wcnt;
  int    m_rptr;
  int    m_dout;
  int    m_zero;
  int    cycles;
  bit    chk_on;
  string tag;

  assign wr_ptr   = wcnt[AW:0];
  assign mem_data = bmem[mem_addr];

  rtx_read_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_rtx_read_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .lat_sel_i  (lat_sel),
    .rd_en_i    (rd_en),
    .rtx_n_i    (rtx_n),
    .wr_ptr_i   (wr_ptr),
    .mem_addr_o (mem_addr),
    .mem_data_i (mem_data),
    .dout_o     (dout),
    .empty_o    (empty)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    int m_empty;
    m_empty = (m_rptr == (wcnt % (2*DEPTH)));
    if (!rst_n) begin
      m_zero = (lat_sel == 1'b0);
      m_rptr = 0;
      m_dout = 0;
    end else if (!rtx_n) begin
      if (m_zero && wcnt != 0) begin
        m_dout = bmem[0];
        m_rptr = 1;
      end else begin
        m_rptr = 0;
      end
    end else if (rd_en && !m_empty) begin
      m_dout = bmem[m_rptr % DEPTH];
      m_rptr = (m_rptr + 1) % (2*DEPTH);
    end
  end

  task automatic check(input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (chk_on) begin
      int e_empty;
      int e_addr;
      e_empty = (m_rptr == (wcnt % (2*DEPTH)));
      e_addr  = (m_zero && !rtx_n) ? 0 : (m_rptr % DEPTH);
      check("dout",  int'(dout),     m_dout);
      check("empty", int'(empty),    e_empty);
      check("addr",  int'(mem_addr), e_addr);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  task automatic step(input logic re, input logic rt);
    @(negedge clk); #1;
    rd_en = re;
    rtx_n = rt;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b1);
  endtask

  task automatic put(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      bmem[wcnt % DEPTH] = DW'(8'h30 + wcnt * 7);
      wcnt++;
      rd_en = 1'b0;
      rtx_n = 1'b1;
    end
  endtask

  task automatic do_reset(input logic sel);
    @(negedge clk); #1;
    rd_en   = 1'b0;
    rtx_n   = 1'b1;
    lat_sel = sel;
    rst_n   = 1'b0;
    wcnt    = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    n_checks = 0; n_errors = 0; cycles = 0; chk_on = 0;
    wcnt = 0; m_rptr = 0; m_dout = 0; m_zero = 0;
    rd_en = 0; rtx_n = 1; lat_sel = 1; rst_n = 0;
    for (int i = 0; i < DEPTH; i++) bmem[i] = '0;
    tag = "R1";
    repeat (2) @(negedge clk);
    chk_on = 1;

    // normal latency
    do_reset(1'b1);
    tag = "R1"; idle(2);
    tag = "R2"; put(5);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
    tag = "R3"; for (int i = 0; i < 4; i++) step(1'b1, 1'b1);
    idle(1);
    tag = "R8"; step(1'b0, 1'b0);
    tag = "R5"; idle(2);
    tag = "R8"; step(1'b1, 1'b1); step(1'b1, 1'b1);
    tag = "R9"; step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    tag = "R4"; put(11);
    for (int i = 0; i < DEPTH + 2; i++) step(1'b1, 1'b1);
    tag = "R5"; step(1'b1, 1'b0); step(1'b1, 1'b1);
    idle(2);

    // zero latency, selector moved after reset
    do_reset(1'b0);
    tag = "R6"; lat_sel = 1'b1;
    tag = "R10"; step(1'b0, 1'b0); idle(2);
    tag = "R7"; put(4);
    step(1'b1, 1'b1); step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    tag = "R6"; for (int i = 0; i < 4; i++) step(1'b1, 1'b1);
    tag = "R9"; step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b1);
    tag = "R7"; step(1'b0, 1'b0); idle(2);

    chk_on = 0;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule